// File: doc/BRIEF.md
# Sliding-Window Multi-SAD Unit

This datapath block scores how well a short run of candidate pixels matches eight neighbouring positions in a strip of reference pixels. A 3-bit select value picks a 4-byte group from the 128-bit candidate operand and an 11-byte strip from the 128-bit reference operand. The block slides the group across the strip one byte at a time. At each of the eight positions it adds up the four unsigned absolute byte differences. The eight totals leave the block as 16-bit lanes of a 128-bit result.

A new operand set can be accepted on every clock. The data passes through two register stages: the first holds the 32 absolute differences and the second holds the eight lane totals. The result appears two cycles after the matching `in_valid` pulse, qualified by `out_valid`. A motion-search engine would issue one request per candidate word and pick the smallest lane.

Top module: `msad_slide_unit`

## Requirements
- R1: `sel[1:0]` = w picks candidate bytes 4w, 4w+1, 4w+2 and 4w+3 as group bytes 0..3, so any of the four 32-bit candidate words can be the group.
- R2: `sel[2]` = 0 makes the strip reference bytes 0..10. `sel[2]` = 1 makes it reference bytes 4..14.
- R3: Lane k (k = 0..7) equals the sum over j = 0..3 of |strip[k+j] − group[j]|, with every byte treated as unsigned.
- R4: Lane k sits in `sad_lanes[16k+15:16k]`, so lane 0 is the least significant 16 bits.
- R5: Bits 15:10 of every lane are zero. The largest lane value is 1020, reached when one operand is all 0x00 and the other is all 0xFF.
- R6: `out_valid` rises exactly two cycles after an accepted `in_valid`, and `sad_lanes` carries the result of those operands in that cycle. Cycles without `in_valid` produce no `out_valid`.
- R7: A low `rst_n` sampled at a clock edge clears the valid pipeline synchronously. `out_valid` is 0 from that edge until two edges after a new `in_valid`.
- R8: Reference byte 15 never changes the result, for either value of `sel[2]`.
- R9: Requests on back-to-back cycles each produce their own result, one per cycle and in the order they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and select are presented this cycle |
| ref_op | input | 128 | Reference operand, byte i at bits 8i+7:8i |
| cand_op | input | 128 | Candidate operand, byte i at bits 8i+7:8i |
| sel | input | 3 | Bits 1:0 pick the candidate word, bit 2 picks the strip start |
| out_valid | output | 1 | `sad_lanes` holds a finished result |
| sad_lanes | output | 128 | Eight 16-bit SAD lanes, lane 0 least significant |

## Verification
Every result is due exactly two rising edges after the edge that samples its request. Nothing is due for an idle cycle, and nothing is due for a request whose first or second edge falls in reset. The bench drives inputs on falling edges and keeps a queue of expected results, one entry per driven cycle. On each falling edge it checks the entry pushed two falling edges earlier, so the comparison always lands in the cycle where the second register stage has updated. A reset drive marks the queued entries that would reach an output after the reset edge as invalid, so the expected `out_valid` follows R7 with no special cases.

// File: rtl/msad_pkg.sv
// Package msad_pkg
// Shared byte type and the absolute-difference helper for the sliding
// SAD unit. Assumes unsigned 8-bit samples throughout.
package msad_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] sample_t;

    // Unsigned absolute difference of two samples; the result always fits in a sample.
    function automatic sample_t abs_diff(input sample_t a, input sample_t b);
        return (a > b) ? sample_t'(a - b) : sample_t'(b - a);
    endfunction

endpackage

// File: rtl/msad_operand_select.sv
// Module msad_operand_select
// Purely combinational. Extracts the GROUP-byte candidate group (one
// GROUP-byte word chosen by sel[1:0]) and the WIN-byte reference strip
// (starting at byte 0 or byte GROUP, chosen by sel[2]).
// Assumes OP_BYTES >= 4*GROUP and OP_BYTES >= GROUP+WIN, true for defaults.
module msad_operand_select
    import msad_pkg::*;
#(
    parameter int OP_BYTES = 16,
    parameter int GROUP    = 4,
    parameter int LANES    = 8,
    localparam int WIN     = LANES + GROUP - 1,
    localparam int OP_W    = OP_BYTES * BYTE_W,
    localparam int GRP_W   = GROUP * BYTE_W
) (
    input  logic [OP_W-1:0]                ref_op,
    input  logic [OP_W-1:0]                cand_op,
    input  logic [2:0]                     sel,
    output logic [WIN-1:0][BYTE_W-1:0]     strip,
    output logic [GROUP-1:0][BYTE_W-1:0]   group
);

    logic [GRP_W-1:0] group_word;

    // Pick the candidate word addressed by sel[1:0].
    always_comb begin
        group_word = cand_op[int'(sel[1:0]) * GRP_W +: GRP_W];
    end

    genvar gi;
    generate
        for (gi = 0; gi < GROUP; gi++) begin : g_group
            assign group[gi] = group_word[gi*BYTE_W +: BYTE_W];
        end
        for (gi = 0; gi < WIN; gi++) begin : g_strip
            // Strip byte gi comes from reference byte gi or gi+GROUP.
            assign strip[gi] = sel[2] ? ref_op[(gi + GROUP)*BYTE_W +: BYTE_W]
                                      : ref_op[gi*BYTE_W +: BYTE_W];
        end
    endgenerate

endmodule

// File: rtl/msad_absdiff_stage.sv
// Module msad_absdiff_stage
// Pipeline stage 1. Forms the LANES x GROUP absolute differences between
// shifted strip bytes and group bytes and registers them. Data registers
// load only on a valid request; only the valid flag is reset.
module msad_absdiff_stage
    import msad_pkg::*;
#(
    parameter int GROUP = 4,
    parameter int LANES = 8,
    localparam int WIN  = LANES + GROUP - 1
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       in_valid,
    input  logic [WIN-1:0][BYTE_W-1:0]                 strip,
    input  logic [GROUP-1:0][BYTE_W-1:0]               group,
    output logic                                       diff_valid,
    output logic [LANES-1:0][GROUP-1:0][BYTE_W-1:0]    diff_q
);

    // Stage-1 valid flag, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) diff_valid <= 1'b0;
        else        diff_valid <= in_valid;
    end

    genvar k, j;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            for (j = 0; j < GROUP; j++) begin : g_tap
                // Capture |strip[k+j] - group[j]| for an accepted request.
                always_ff @(posedge clk) begin
                    if (in_valid) diff_q[k][j] <= abs_diff(strip[k+j], group[j]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/msad_lane_adder.sv
// Module msad_lane_adder
// Pipeline stage 2. Adds the GROUP differences of each lane and registers
// the LANES totals, zero-extended to LANE_W bits in the packed result.
// Assumes LANE_W >= SUM_W.
module msad_lane_adder
    import msad_pkg::*;
#(
    parameter int GROUP  = 4,
    parameter int LANES  = 8,
    parameter int LANE_W = 16,
    localparam int SUM_W = $clog2(GROUP * ((1 << BYTE_W) - 1) + 1)
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       diff_valid,
    input  logic [LANES-1:0][GROUP-1:0][BYTE_W-1:0]    diff_q,
    output logic                                       out_valid,
    output logic [LANES*LANE_W-1:0]                    sad_lanes
);

    logic [LANES-1:0][SUM_W-1:0] lane_sum_d;
    logic [LANES-1:0][SUM_W-1:0] lane_sum_q;

    // Sum the differences belonging to each lane.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_sum_d[k] = '0;
            for (int j = 0; j < GROUP; j++) begin
                lane_sum_d[k] = lane_sum_d[k] + SUM_W'(diff_q[k][j]);
            end
        end
    end

    // Stage-2 valid flag, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= diff_valid;
    end

    // Register lane totals when stage 1 holds a request.
    always_ff @(posedge clk) begin
        if (diff_valid) lane_sum_q <= lane_sum_d;
    end

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_pack
            assign sad_lanes[k*LANE_W +: LANE_W] = {{(LANE_W-SUM_W){1'b0}}, lane_sum_q[k]};
        end
    endgenerate

endmodule

// File: rtl/msad_slide_unit.sv
// Module msad_slide_unit
// Top level of the sliding-window multi-SAD unit: operand selection,
// a registered difference stage and a registered lane-sum stage.
// Latency is two cycles and one request is accepted per cycle.
// Synchronous active-low reset clears only the valid pipeline.
module msad_slide_unit
    import msad_pkg::*;
#(
    parameter int OP_BYTES = 16,
    parameter int GROUP    = 4,
    parameter int LANES    = 8,
    parameter int LANE_W   = 16,
    localparam int WIN     = LANES + GROUP - 1,
    localparam int OP_W    = OP_BYTES * BYTE_W,
    localparam int RES_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   ref_op,
    input  logic [OP_W-1:0]   cand_op,
    input  logic [2:0]        sel,
    output logic              out_valid,
    output logic [RES_W-1:0]  sad_lanes
);

    logic [WIN-1:0][BYTE_W-1:0]              strip;
    logic [GROUP-1:0][BYTE_W-1:0]            group;
    logic                                    diff_valid;
    logic [LANES-1:0][GROUP-1:0][BYTE_W-1:0] diff_q;

    msad_operand_select #(
        .OP_BYTES (OP_BYTES),
        .GROUP    (GROUP),
        .LANES    (LANES)
    ) u_select (
        .ref_op   (ref_op),
        .cand_op  (cand_op),
        .sel      (sel),
        .strip    (strip),
        .group    (group)
    );

    msad_absdiff_stage #(
        .GROUP      (GROUP),
        .LANES      (LANES)
    ) u_diff (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .strip      (strip),
        .group      (group),
        .diff_valid (diff_valid),
        .diff_q     (diff_q)
    );

    msad_lane_adder #(
        .GROUP      (GROUP),
        .LANES      (LANES),
        .LANE_W     (LANE_W)
    ) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .diff_valid (diff_valid),
        .diff_q     (diff_q),
        .out_valid  (out_valid),
        .sad_lanes  (sad_lanes)
    );

endmodule

// File: rtl/msad_slide_chk.sv
// Module msad_slide_chk
// Property checker for msad_slide_unit, attached through bind below.
// Assumes the top's default byte width and a reset applied at start-up.
module msad_slide_chk #(
    parameter int OP_BYTES = 16,
    parameter int GROUP    = 4,
    parameter int LANES    = 8,
    parameter int LANE_W   = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [OP_BYTES*8-1:0]     ref_op,
    input logic [OP_BYTES*8-1:0]     cand_op,
    input logic [2:0]                sel,
    input logic                      out_valid,
    input logic [LANES*LANE_W-1:0]   sad_lanes
);

    localparam int MAX_LANE = GROUP * 255;
    localparam int GRP_W    = GROUP * 8;

    logic [1:0] since_rst;

    // Count edges since reset, saturating at two, so $past stays inside history.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R6
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R3
    match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && out_valid && $past(sel, 2) == 3'b000 &&
         $past(ref_op[GRP_W-1:0], 2) == $past(cand_op[GRP_W-1:0], 2))
        |-> (sad_lanes[LANE_W-1:0] == '0));

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane_chk
            // R5
            lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (int'(sad_lanes[k*LANE_W +: LANE_W]) <= MAX_LANE));
        end
    endgenerate

endmodule

bind msad_slide_unit msad_slide_chk #(
    .OP_BYTES (OP_BYTES),
    .GROUP    (GROUP),
    .LANES    (LANES),
    .LANE_W   (LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ref_op    (ref_op),
    .cand_op   (cand_op),
    .sel       (sel),
    .out_valid (out_valid),
    .sad_lanes (sad_lanes)
);

// File: tb/sim_msad_slide_unit.sv
`timescale 1ns/1ps
// Bench for msad_slide_unit: falling-edge stimulus, a queue of expected
// results, and a check two falling edges after each drive.
module sim_msad_slide_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] ref_op = '0;
    logic [127:0] cand_op = '0;
    logic [2:0]   sel = '0;
    logic         out_valid;
    logic [127:0] sad_lanes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit           v;
        logic [127:0] res;
        string        tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    msad_slide_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ref_op    (ref_op),
        .cand_op   (cand_op),
        .sel       (sel),
        .out_valid (out_valid),
        .sad_lanes (sad_lanes)
    );

    // Behavioural model of the eight lane sums.
    function automatic logic [127:0] model(input logic [127:0] r, input logic [127:0] c,
                                           input logic [2:0] s);
        logic [127:0] res = '0;
        int rb = s[2] ? 4 : 0;
        int cb = int'(s[1:0]) * 4;
        for (int k = 0; k < 8; k++) begin
            int acc = 0;
            for (int j = 0; j < 4; j++) begin
                int a = int'(r[(rb + k + j)*8 +: 8]);
                int b = int'(c[(cb + j)*8 +: 8]);
                acc += (a > b) ? a - b : b - a;
            end
            res[k*16 +: 16] = 16'(acc);
        end
        return res;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (out_valid !== e.v) begin
            errors++;
            $display("FAIL %s out_valid got %0b exp %0b", e.tag, out_valid, e.v);
        end
        if (e.v) begin
            for (int k = 0; k < 8; k++) begin
                checks++;
                if (sad_lanes[k*16 +: 16] !== e.res[k*16 +: 16]) begin
                    errors++;
                    $display("FAIL %s R4 lane %0d got %0d exp %0d", e.tag, k,
                             sad_lanes[k*16 +: 16], e.res[k*16 +: 16]);
                end
            end
        end
    endtask

    // One cycle: check the result due now, then drive the next inputs.
    task automatic step(input bit v, input logic [127:0] r, input logic [127:0] c,
                        input logic [2:0] s, input string tag, input bit rst_lvl);
        exp_t e;
        @(negedge clk);
        if (q.size() == 2) begin
            compare(q[0]);
            void'(q.pop_front());
        end
        rst_n = rst_lvl; in_valid = v; ref_op = r; cand_op = c; sel = s;
        if (!rst_lvl) foreach (q[i]) q[i].v = 1'b0;
        e.v = v && rst_lvl;
        e.res = model(r, c, s);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic go(input logic [127:0] r, input logic [127:0] c, input logic [2:0] s,
                      input string tag);
        step(1'b1, r, c, s, tag, 1'b1);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, '0, 3'd0, tag, 1'b1);
    endtask

    initial begin
        logic [127:0] r;
        logic [127:0] c;
        // R7: reset state, requests ignored while reset is low
        for (int i = 0; i < 4; i++) step(1'b1, rnd128(), rnd128(), 3'd0, "R7", 1'b0);
        idle("R7");
        idle("R7");
        // R1 R2 R3: every select value with random operands
        for (int s = 0; s < 8; s++) go(rnd128(), rnd128(), 3'(s), (s < 4) ? "R1" : "R2");
        for (int s = 0; s < 8; s++) go(rnd128(), rnd128(), 3'(s), "R3");
        // R5: extremes give 1020 per lane
        for (int s = 0; s < 8; s++) go('0, {128{1'b1}}, 3'(s), "R5");
        for (int s = 0; s < 8; s++) go({128{1'b1}}, '0, 3'(s), "R5");
        // R4: ramp reference against zero candidate gives distinct lanes
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(i * 9 + 1);
        go(r, '0, 3'd0, "R4");
        go(r, '0, 3'd4, "R4");
        // R8: byte 15 of the reference has no effect
        r = rnd128(); c = rnd128();
        go(r, c, 3'd5, "R8");
        r[127:120] = ~r[127:120];
        go(r, c, 3'd5, "R8");
        go(r, c, 3'd2, "R8");
        // R6: isolated requests separated by bubbles
        for (int i = 0; i < 4; i++) begin
            go(rnd128(), rnd128(), 3'($urandom), "R6");
            idle("R6");
            idle("R6");
        end
        // R9: long back-to-back stream
        for (int i = 0; i < 24; i++) go(rnd128(), rnd128(), 3'($urandom), "R9");
        // R7: reset in mid-stream drops in-flight results
        go(rnd128(), rnd128(), 3'd1, "R7");
        go(rnd128(), rnd128(), 3'd6, "R7");
        step(1'b1, rnd128(), rnd128(), 3'd3, "R7", 1'b0);
        go(rnd128(), rnd128(), 3'd7, "R7");
        go(rnd128(), rnd128(), 3'd2, "R7");
        for (int i = 0; i < 4; i++) idle("R6");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule